// File: doc/BRIEF.md
# Accumulator ALU with BCD adjust

A purely combinational 8-bit arithmetic and logic unit for an accumulator-style microcontroller datapath. Each cycle it takes the accumulator byte, a second operand byte, the B register byte and the incoming carry and auxiliary-carry flags, together with a 4-bit operation code. From these it forms a result byte for the accumulator and a result byte for the B register. It also returns new carry (CY), auxiliary-carry (AC) and overflow (OV) values, each with its own write enable.

The surrounding core decodes instructions and fetches the operands. It writes `res_o` back to the accumulator and `breg_o` back to B. It commits each flag only when that flag's enable is high. Multiply and divide spread their results over both A and B. Decimal adjust corrects a packed-BCD sum in two steps, one per nibble, steered by AC and CY.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) gives `res_o` = A + operand mod 256. Op 1 (add with carry) also adds `cy_i`. Both drive all three flag enables high. CY is the carry out of bit 7 and AC the carry out of bit 3. OV is set when two operands of equal sign give a result of the other sign.
- R2: Op 2 (subtract with borrow) gives `res_o` = A − operand − `cy_i` mod 256, with all three flag enables high. CY is set when a borrow is needed out of bit 7. AC is set when the low nibbles need a borrow. OV is set when operands of opposite sign give a result whose sign differs from A.
- R3: Op 3 (increment) and op 4 (decrement) act on A. Increment wraps 0xFF to 0x00 and decrement wraps 0x00 to 0xFF. Neither op raises any flag enable.
- R4: Op 5 (AND), op 6 (OR) and op 7 (XOR) combine A with the operand bit by bit. Op 8 inverts every bit of A. None of these four ops raises any flag enable.
- R5: Op 9 exchanges bits 7..4 of A with bits 3..0. Op 10 rotates A right by one place, with bit 0 moving into bit 7. Neither op raises any flag enable.
- R6: Op 11 (decimal adjust) first adds 0x06 to A when the low nibble is above 9 or `ac_i` is 1. A carry out of bit 7 from this step sets CY. It then adds 0x60 when the high nibble of that value is above 9 or CY is 1, and the correction sets CY. CY is never cleared by this op: the CY enable is high, and the AC and OV enables are low. Example: 0xAB with both flags clear gives 0x11 with CY=1.
- R7: Op 11 applied to a value that is already valid BCD, with AC and CY clear, returns A unchanged with CY=0. Example: 0x78.
- R8: Op 12 (multiply) forms the unsigned 16-bit product of A and B. The low byte goes to `res_o` and the high byte to `breg_o`. CY is cleared, and OV is set exactly when the product exceeds 0xFF. Example: 0x45 × 0xF5 gives A=0x09 and B=0x42.
- R9: Op 13 (divide) with B nonzero gives the unsigned quotient A/B on `res_o` and the remainder on `breg_o`, with CY and OV cleared.
- R10: Op 13 with B equal to zero sets OV and clears CY. The A and B results are a fixed function of the inputs.
- R11: For every op other than 12 and 13, `breg_o` equals `breg_i`. Whenever a flag's enable is low, `cy_o` equals `cy_i`, `ac_o` equals `ac_i` and `ov_o` is 0. Op codes 14 and 15 return A unchanged with no enable raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand for add, subtract and bitwise ops |
| breg_i | input | 8 | B register operand for multiply and divide |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary-carry flag |
| res_o | output | 8 | Accumulator result |
| breg_o | output | 8 | B register result |
| cy_o | output | 1 | New carry flag value |
| ac_o | output | 1 | New auxiliary-carry flag value |
| ov_o | output | 1 | New overflow flag value |
| cy_we_o | output | 1 | Carry flag write enable |
| ac_we_o | output | 1 | Auxiliary-carry flag write enable |
| ov_we_o | output | 1 | Overflow flag write enable |

## Verification
On every evaluation the assertions check several arithmetic identities. The adder's carry and sum together equal the true sum, and the subtract result plus the subtrahend gives back A. The shift-add product matches a plain multiply, and the quotient times B plus the remainder rebuilds A with the remainder below B. The assertions also check that decimal adjust never clears a set CY, and that the bitwise, shift and increment ops never raise a flag enable. Only the bench scenarios show the exact flag values. These cover signed overflow at 0x7F+1, a borrow from zero, the two-step decimal correction of 0xAB, the untouched BCD value 0x78, divide by zero and the unused op codes, alongside many random operand mixes.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_SWAP = 4'd9,
    OP_RR   = 4'd10,
    OP_DA   = 4'd11,
    OP_MUL  = 4'd12,
    OP_DIV  = 4'd13
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
module acc_alu_addsub #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,   // carry in (add) or borrow in (sub)
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o
);
  localparam int unsigned NW = DW / 2;

  logic [DW-1:0] bx;
  logic          cx;
  logic [NW:0]   lo_sum;
  logic [DW-1:0] low_sum;
  logic [1:0]    top_sum;
  logic          c_msb_in;

  assign bx = sub_i ? ~b_i : b_i;
  assign cx = sub_i ? ~cin_i : cin_i;

  assign lo_sum   = {1'b0, a_i[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cx};
  assign low_sum  = {1'b0, a_i[DW-2:0]} + {1'b0, bx[DW-2:0]} + {{(DW-1){1'b0}}, cx};
  assign c_msb_in = low_sum[DW-1];
  assign top_sum  = {1'b0, a_i[DW-1]} + {1'b0, bx[DW-1]} + {1'b0, c_msb_in};

  assign res_o = {top_sum[0], low_sum[DW-2:0]};
  // subtract reports borrows, the inverse of adder carries
  assign cy_o  = sub_i ? ~top_sum[1] : top_sum[1];
  assign ac_o  = sub_i ? ~lo_sum[NW] : lo_sum[NW];
  assign ov_o  = c_msb_in ^ top_sum[1];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i, sub_i})) begin
      if (!sub_i) begin
        p_add_sum_r1: assert ({cy_o, res_o} == ({1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i}))
          else $error("add sum/carry mismatch");
      end else begin
        p_sub_diff_r2: assert ((res_o + b_i + {{(DW-1){1'b0}}, cin_i}) == a_i)
          else $error("subtract difference mismatch");
        p_sub_borrow_r2: assert (cy_o == ({1'b0, a_i} < ({1'b0, b_i} + {{DW{1'b0}}, cin_i})))
          else $error("subtract borrow mismatch");
      end
    end
  end
endmodule

// File: rtl/acc_alu_decadj.sv
`timescale 1ns/1ps
module acc_alu_decadj #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          ac_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  localparam int unsigned NW = DW / 2;
  localparam logic [DW:0]   LO_ADJ = (DW+1)'(6);
  localparam logic [DW:0]   HI_ADJ = LO_ADJ << NW;
  localparam logic [NW-1:0] NINE   = NW'(9);

  logic          lo_fix, hi_fix, c1;
  logic [DW:0]   s1, s2;

  assign lo_fix = (a_i[NW-1:0] > NINE) || ac_i;
  assign s1     = lo_fix ? ({1'b0, a_i} + LO_ADJ) : {1'b0, a_i};
  assign c1     = cy_i | s1[DW];
  assign hi_fix = (s1[DW-1:NW] > NINE) || c1;
  assign s2     = hi_fix ? ({1'b0, s1[DW-1:0]} + HI_ADJ) : {1'b0, s1[DW-1:0]};
  assign res_o  = s2[DW-1:0];
  assign cy_o   = c1 | s2[DW] | hi_fix;

  always_comb begin
    if (!$isunknown({a_i, ac_i, cy_i})) begin
      p_da_sticky_r6: assert (!cy_i || cy_o)
        else $error("decimal adjust cleared carry");
      p_da_keep_r7: assert (ac_i || cy_i || (a_i[NW-1:0] > NINE) || (a_i[DW-1:NW] > NINE)
                            || (res_o == a_i && !cy_o))
        else $error("decimal adjust altered valid BCD");
    end
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
`timescale 1ns/1ps
module acc_alu_muldiv #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] prod_o,
  output logic [DW-1:0]   quo_o,
  output logic [DW-1:0]   rem_o
);
  localparam int unsigned PW = 2 * DW;

  // shift-add multiplier, one row per multiplier bit
  logic [PW-1:0] pp_acc [DW+1];
  assign pp_acc[0] = '0;
  for (genvar i = 0; i < DW; i++) begin : g_mul_row
    logic [PW-1:0] row;
    assign row          = b_i[i] ? ({{DW{1'b0}}, a_i} << i) : '0;
    assign pp_acc[i+1]  = pp_acc[i] + row;
  end
  assign prod_o = pp_acc[DW];

  // restoring divider, MSB first; B=0 yields quotient all ones, remainder A
  logic [DW:0] part [DW+1];
  assign part[0] = '0;
  for (genvar i = 0; i < DW; i++) begin : g_div_stage
    logic [DW:0] shifted, diff;
    assign shifted       = {part[i][DW-1:0], a_i[DW-1-i]};
    assign diff          = shifted - {1'b0, b_i};
    assign quo_o[DW-1-i] = ~diff[DW];
    assign part[i+1]     = diff[DW] ? shifted : diff;
  end
  assign rem_o = part[DW][DW-1:0];

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      p_mul_prod_r8: assert (prod_o == ({{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i}))
        else $error("product mismatch");
      if (b_i != '0) begin
        p_div_rebuild_r9: assert (({{DW{1'b0}}, quo_o} * {{DW{1'b0}}, b_i} + {{DW{1'b0}}, rem_o})
                                  == {{DW{1'b0}}, a_i} && rem_o < b_i)
          else $error("quotient/remainder mismatch");
      end
    end
  end
endmodule

// File: rtl/acc_alu_bitops.sv
`timescale 1ns/1ps
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned NW = DW / 2;

  always_comb begin
    case (op_i)
      OP_INC:  res_o = a_i + DW'(1);
      OP_DEC:  res_o = a_i - DW'(1);
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CPL:  res_o = ~a_i;
      OP_SWAP: res_o = {a_i[NW-1:0], a_i[DW-1:NW]};
      OP_RR:   res_o = {a_i[0], a_i[DW-1:1]};
      default: res_o = a_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, a_i})) begin
      if (op_i == OP_RR) begin
        p_rr_rebuild_r5: assert ({res_o[DW-2:0], res_o[DW-1]} == a_i)
          else $error("rotate mismatch");
      end
      if (op_i == OP_INC) begin
        p_inc_wrap_r3: assert ((a_i != '1) || (res_o == '0))
          else $error("increment wrap");
      end
      if (op_i == OP_DEC) begin
        p_dec_wrap_r3: assert ((a_i != '0) || (res_o == '1))
          else $error("decrement wrap");
      end
    end
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] breg_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] breg_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o,
  output logic          cy_we_o,
  output logic          ac_we_o,
  output logic          ov_we_o
);
  logic [DW-1:0]   as_res, da_res, bit_res, quo, rem;
  logic [2*DW-1:0] prod;
  logic            as_cy, as_ac, as_ov, da_cy, as_cin, as_sub;

  assign as_sub = (op_i == OP_SUBB);
  assign as_cin = (op_i == OP_ADD) ? 1'b0 : cy_i;

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  acc_alu_decadj #(.DW(DW)) u_decadj (
    .a_i(acc_i), .ac_i(ac_i), .cy_i(cy_i), .res_o(da_res), .cy_o(da_cy)
  );

  acc_alu_muldiv #(.DW(DW)) u_muldiv (
    .a_i(acc_i), .b_i(breg_i), .prod_o(prod), .quo_o(quo), .rem_o(rem)
  );

  acc_alu_bitops #(.DW(DW)) u_bitops (
    .op_i(op_i), .a_i(acc_i), .b_i(opnd_i), .res_o(bit_res)
  );

  always_comb begin
    res_o   = acc_i;
    breg_o  = breg_i;
    cy_o    = cy_i;
    ac_o    = ac_i;
    ov_o    = 1'b0;
    cy_we_o = 1'b0;
    ac_we_o = 1'b0;
    ov_we_o = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_o   = as_res;
        cy_o    = as_cy;
        ac_o    = as_ac;
        ov_o    = as_ov;
        cy_we_o = 1'b1;
        ac_we_o = 1'b1;
        ov_we_o = 1'b1;
      end
      OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CPL, OP_SWAP, OP_RR: begin
        res_o = bit_res;
      end
      OP_DA: begin
        res_o   = da_res;
        cy_o    = da_cy;
        cy_we_o = 1'b1;
      end
      OP_MUL: begin
        res_o   = prod[DW-1:0];
        breg_o  = prod[2*DW-1:DW];
        cy_o    = 1'b0;
        ov_o    = |prod[2*DW-1:DW];
        cy_we_o = 1'b1;
        ov_we_o = 1'b1;
      end
      OP_DIV: begin
        res_o   = quo;
        breg_o  = rem;
        cy_o    = 1'b0;
        ov_o    = (breg_i == '0);
        cy_we_o = 1'b1;
        ov_we_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, acc_i, opnd_i, breg_i, cy_i, ac_i})) begin
      if (op_i >= OP_INC && op_i <= OP_RR) begin
        p_no_flag_we_r4: assert (!cy_we_o && !ac_we_o && !ov_we_o)
          else $error("flag enable on flagless op");
      end
      if (op_i != OP_MUL && op_i != OP_DIV) begin
        p_b_pass_r11: assert (breg_o == breg_i)
          else $error("B changed on non mul/div op");
      end
      p_flag_hold_r11: assert ((cy_we_o || cy_o == cy_i) && (ac_we_o || ac_o == ac_i)
                               && (ov_we_o || !ov_o))
        else $error("unwritten flag not passed through");
      if (op_i == OP_DIV && breg_i == '0) begin
        p_div_zero_r10: assert (ov_we_o && ov_o && cy_we_o && !cy_o)
          else $error("divide by zero flags");
      end
      if (op_i == OP_MUL) begin
        p_mul_ov_r8: assert (ov_o == (breg_o != '0))
          else $error("multiply overflow flag");
      end
    end
  end
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] op;
  logic [7:0] acc, opnd, breg, res, breg_o;
  logic       cy, ac, cy_o, ac_o, ov_o, cy_we, ac_we, ov_we;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  acc_alu u0 (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .breg_i(breg), .cy_i(cy), .ac_i(ac),
    .res_o(res), .breg_o(breg_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
    .cy_we_o(cy_we), .ac_we_o(ac_we), .ov_we_o(ov_we)
  );

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] b;
    logic [5:0] f;   // cy, ac, ov, cy_we, ac_we, ov_we
    logic       care;
  } exp_t;

  function automatic string tag(input logic [3:0] o, input logic [7:0] a, input logic [7:0] bb);
    case (o)
      4'd0, 4'd1: return "R1";
      4'd2:       return "R2";
      4'd3, 4'd4: return "R3";
      4'd5, 4'd6, 4'd7, 4'd8: return "R4";
      4'd9, 4'd10: return "R5";
      4'd11: return (a[3:0] <= 4'd9 && a[7:4] <= 4'd9) ? "R7" : "R6";
      4'd12: return "R8";
      4'd13: return (bb == 8'd0) ? "R10" : "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic exp_t model(input logic [3:0] o, input logic [7:0] a8, input logic [7:0] d8,
                                 input logic [7:0] b8, input logic ci, input logic hi);
    exp_t e;
    int a = a8, d = d8, bb = b8, c = ci, h = hi;
    int t, s, fc, fa, fo;
    e.r = a8; e.b = b8; e.care = 1'b1;
    e.f = {ci, hi, 1'b0, 3'b000};
    case (o)
      4'd0, 4'd1: begin
        t  = (o == 4'd1) ? c : 0;
        s  = a + d + t;
        fc = (s > 255);
        fa = ((a % 16) + (d % 16) + t) > 15;
        t  = sx(a) + sx(d) + t;
        fo = (t > 127) || (t < -128);
        e.r = s[7:0]; e.f = {fc[0], fa[0], fo[0], 3'b111};
      end
      4'd2: begin
        s  = a - d - c;
        fc = (s < 0);
        fa = ((a % 16) - (d % 16) - c) < 0;
        t  = sx(a) - sx(d) - c;
        fo = (t > 127) || (t < -128);
        e.r = 8'((s + 256) % 256); e.f = {fc[0], fa[0], fo[0], 3'b111};
      end
      4'd3: e.r = 8'((a + 1) % 256);
      4'd4: e.r = 8'((a + 255) % 256);
      4'd5: e.r = a8 & d8;
      4'd6: e.r = a8 | d8;
      4'd7: e.r = a8 ^ d8;
      4'd8: e.r = 8'(255 - a);
      4'd9: e.r = 8'((a % 16) * 16 + a / 16);
      4'd10: e.r = 8'((a / 2) + (a % 2) * 128);
      4'd11: begin
        t = a; fc = c;
        if ((t % 16) > 9 || h) t = t + 6;
        if (t > 255) begin fc = 1; t = t - 256; end
        if ((t / 16) > 9 || fc) begin t = t + 96; fc = 1; end
        e.r = 8'(t % 256); e.f = {fc[0], hi, 1'b0, 3'b100};
      end
      4'd12: begin
        s = a * bb;
        e.r = 8'(s % 256); e.b = 8'(s / 256);
        e.f = {1'b0, hi, (s > 255), 3'b101};
      end
      4'd13: begin
        if (bb == 0) begin
          e.care = 1'b0; e.f = {1'b0, hi, 1'b1, 3'b101};
        end else begin
          e.r = 8'(a / bb); e.b = 8'(a % bb);
          e.f = {1'b0, hi, 1'b0, 3'b101};
        end
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] bb, input logic ci, input logic hi);
    exp_t e;
    logic [5:0] got;
    @(negedge clk);
    op = o; acc = a; opnd = d; breg = bb; cy = ci; ac = hi;
    #1;
    e   = model(o, a, d, bb, ci, hi);
    got = {cy_o, ac_o, ov_o, cy_we, ac_we, ov_we};
    n_vec++;
    if (got != e.f || (e.care && (res != e.r || breg_o != e.b))) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h d=%h b=%h cy=%b ac=%b: got res=%h b=%h f=%b exp res=%h b=%h f=%b",
               tag(o, a, bb), o, a, d, bb, ci, hi, res, breg_o, got, e.r, e.b, e.f);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    op = 0; acc = 0; opnd = 0; breg = 0; cy = 0; ac = 0;
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    apply(4'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);   // R1 all-zero start
    apply(4'd0, 8'h53, 8'h58, 8'h00, 1'b0, 1'b0);   // R1 -> 0xAB
    apply(4'd11, 8'hAB, 8'h00, 8'h00, 1'b0, 1'b0);  // R6 -> 0x11, CY
    apply(4'd11, 8'h78, 8'h00, 8'h00, 1'b0, 1'b0);  // R7 unchanged
    apply(4'd11, 8'h99, 8'h00, 8'h00, 1'b0, 1'b1);  // R6 low via AC
    apply(4'd11, 8'h12, 8'h00, 8'h00, 1'b1, 1'b0);  // R6 high via CY
    apply(4'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 1'b0);   // R1 signed overflow
    apply(4'd1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0);   // R1 carry-in wrap
    apply(4'd2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);   // R2 borrow
    apply(4'd2, 8'h80, 8'h00, 8'h00, 1'b1, 1'b1);   // R2 overflow via borrow
    apply(4'd3, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0);   // R3 inc wrap
    apply(4'd4, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);   // R3 dec wrap
    apply(4'd8, 8'h5A, 8'h00, 8'h00, 1'b1, 1'b1);   // R4 complement
    apply(4'd9, 8'h3C, 8'h00, 8'h00, 1'b0, 1'b0);   // R5 swap
    apply(4'd10, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);  // R5 rotate
    apply(4'd12, 8'h45, 8'h00, 8'hF5, 1'b1, 1'b0);  // R8 -> 09/42
    apply(4'd12, 8'h0F, 8'h00, 8'h11, 1'b1, 1'b0);  // R8 no overflow
    apply(4'd13, 8'hE8, 8'h00, 8'h1B, 1'b1, 1'b0);  // R9 -> 08 r 10
    apply(4'd13, 8'h37, 8'h00, 8'h00, 1'b1, 1'b1);  // R10 divide by zero
    apply(4'd14, 8'hC3, 8'h11, 8'h22, 1'b1, 1'b0);  // R11 unused op
    apply(4'd15, 8'h3C, 8'h44, 8'h55, 1'b0, 1'b1);  // R11 unused op
    for (int i = 0; i < 4000; i++) begin
      apply(4'($urandom_range(15, 0)), 8'($urandom), 8'($urandom),
            (i % 50 == 0) ? 8'h00 : 8'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule